// File: doc/BRIEF.md
# Decimal Adjust and Accumulator Bit-Operation Unit

This block post-processes an 8-bit accumulator. It takes the accumulator value, a carry flag and an auxiliary (half) carry flag, all produced by an earlier step such as an addition. It then applies one of eight operations. The first is a packed-BCD decimal correction of the two digits after a binary add. Four single-bit rotates follow; they differ only in whether the carry flag sits inside the rotation loop. The remaining three are complement of the accumulator, complement of carry and forcing carry to one.

The result and the status flags are registered, and the register loads only on a cycle where the enable is high. A surrounding datapath or a testbench can therefore step through a sequence one operation at a time. An example is a binary add computed outside, followed by a decimal correction here. The flags held by the unit are carry, auxiliary carry, zero, sign and even parity.

Top module: `acc_adjust_unit`

## Requirements
- R1: While rst_n is low, acc_q is 0x00 and cy_q, ac_q, zero_q, sign_q and par_q are all 0.
- R2: On a rising clock edge with en low, none of the outputs changes.
- R3: On a rising clock edge with en high, the outputs take the result of the operation selected by op, with op 0 = decimal adjust, 1 = rotate left circular, 2 = rotate right circular, 3 = rotate left through carry, 4 = rotate right through carry, 5 = complement accumulator, 6 = complement carry, 7 = set carry.
- R4: Decimal adjust adds 6 to the accumulator when acc_in[3:0] exceeds 9 or ac_in is 1. ac_q is then 1 exactly when that addition carries out of bit 3.
- R5: Decimal adjust then adds 0x60 when bits [7:4] of the low-corrected value exceed 9, when cy_in is 1, or when the low step carried out of bit 7. cy_q is 1 when cy_in is 1 or when either step carries out of bit 7.
- R6: After decimal adjust, zero_q is 1 for a zero result, sign_q equals result bit 7, and par_q is 1 when the result has an even number of one bits.
- R7: Rotate left circular sends acc_in[7] to both acc_q[0] and cy_q. Rotate right circular sends acc_in[0] to both acc_q[7] and cy_q.
- R8: Rotate left through carry sends acc_in[7] to cy_q and cy_in to acc_q[0]. Rotate right through carry sends acc_in[0] to cy_q and cy_in to acc_q[7].
- R9: For the four rotates, ac_q takes ac_in, and zero_q, sign_q and par_q keep their previous values.
- R10: Complement accumulator loads the bitwise inverse of acc_in. cy_q and ac_q take cy_in and ac_in, and zero_q, sign_q and par_q keep their previous values.
- R11: Complement carry loads acc_in unchanged with cy_q = not cy_in. Set carry loads acc_in unchanged with cy_q = 1. In both cases ac_q takes ac_in, and zero_q, sign_q and par_q keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the result register |
| op | input | 3 | Operation select |
| acc_in | input | 8 | Accumulator value to process |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary carry flag |
| acc_q | output | 8 | Registered accumulator result |
| cy_q | output | 1 | Registered carry flag |
| ac_q | output | 1 | Registered auxiliary carry flag |
| zero_q | output | 1 | Registered zero flag |
| sign_q | output | 1 | Registered sign flag |
| par_q | output | 1 | Registered even-parity flag |

## Verification
The only hidden state is the held zero, sign and parity flags. A fault in how they are kept shows only after a rotate or complement that follows a decimal adjust. The bench therefore mixes operation orders freely, so a stale or wrongly cleared flag appears at the ports in the cycle after the operation that should have kept it. Errors in the decimal path, such as testing the high digit before the low correction or dropping the incoming carry, show in acc_q and cy_q one clock after an enabled adjust. The bench provokes them with add-then-adjust pairs, including sums that overflow eight bits.

// File: rtl/acc_adjust_pkg.sv
package acc_adjust_pkg;
  localparam int ACC_W = 8;
  localparam int DIG_W = 4;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_DADJ = 3'd0,
    OP_RLC  = 3'd1,
    OP_RRC  = 3'd2,
    OP_RLT  = 3'd3,
    OP_RRT  = 3'd4,
    OP_CPLA = 3'd5,
    OP_CPLC = 3'd6,
    OP_SETC = 3'd7
  } adj_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic zero;
    logic sign;
    logic par;
  } adj_flags_t;
endpackage

// File: rtl/dec_adjust.sv
module dec_adjust
  import acc_adjust_pkg::*;
(
  input  logic [ACC_W-1:0] acc,
  input  logic             cy,
  input  logic             ac,
  output logic [ACC_W-1:0] res,
  output logic             cy_out,
  output logic             ac_out
);
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(9);
  localparam logic [DIG_W-1:0] DIG_FIX = DIG_W'(6);

  logic             lo_fix;
  logic             hi_fix;
  logic [DIG_W:0]   lo_sum;
  logic [ACC_W:0]   step1;
  logic [ACC_W:0]   step2;

  always_comb begin
    lo_fix = (acc[DIG_W-1:0] > DIG_MAX) || ac;
    lo_sum = {1'b0, acc[DIG_W-1:0]} + {1'b0, (lo_fix ? DIG_FIX : '0)};
    step1  = {1'b0, acc} + {{(ACC_W+1-DIG_W){1'b0}}, (lo_fix ? DIG_FIX : '0)};
    hi_fix = (step1[ACC_W-1:DIG_W] > DIG_MAX) || cy || step1[ACC_W];
    step2  = {1'b0, step1[ACC_W-1:0]}
           + {1'b0, (hi_fix ? DIG_FIX : '0), {DIG_W{1'b0}}};
    res    = step2[ACC_W-1:0];
    cy_out = cy | step1[ACC_W] | step2[ACC_W];
    ac_out = lo_sum[DIG_W];
  end
endmodule

// File: rtl/acc_bit_ops.sv
module acc_bit_ops
  import acc_adjust_pkg::*;
(
  input  adj_op_e          op,
  input  logic [ACC_W-1:0] acc,
  input  logic             cy,
  output logic [ACC_W-1:0] res,
  output logic             cy_out
);
  always_comb begin
    res    = acc;
    cy_out = cy;
    unique case (op)
      OP_RLC: begin
        res    = {acc[ACC_W-2:0], acc[ACC_W-1]};
        cy_out = acc[ACC_W-1];
      end
      OP_RRC: begin
        res    = {acc[0], acc[ACC_W-1:1]};
        cy_out = acc[0];
      end
      OP_RLT: begin
        res    = {acc[ACC_W-2:0], cy};
        cy_out = acc[ACC_W-1];
      end
      OP_RRT: begin
        res    = {cy, acc[ACC_W-1:1]};
        cy_out = acc[0];
      end
      OP_CPLA: res    = ~acc;
      OP_CPLC: cy_out = ~cy;
      OP_SETC: cy_out = 1'b1;
      default: begin
        res    = acc;
        cy_out = cy;
      end
    endcase
  end
endmodule

// File: rtl/acc_adjust_unit.sv
module acc_adjust_unit
  import acc_adjust_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OP_W-1:0]  op,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             cy_in,
  input  logic             ac_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             cy_q,
  output logic             ac_q,
  output logic             zero_q,
  output logic             sign_q,
  output logic             par_q
);
  adj_op_e          op_e;
  logic [ACC_W-1:0] da_res;
  logic             da_cy;
  logic             da_ac;
  logic [ACC_W-1:0] bo_res;
  logic             bo_cy;

  logic [ACC_W-1:0] acc_r, acc_nx;
  adj_flags_t       flg_r, flg_nx;

  assign op_e = adj_op_e'(op);

  dec_adjust u_dadj (
    .acc(acc_in), .cy(cy_in), .ac(ac_in),
    .res(da_res), .cy_out(da_cy), .ac_out(da_ac)
  );

  acc_bit_ops u_bops (
    .op(op_e), .acc(acc_in), .cy(cy_in),
    .res(bo_res), .cy_out(bo_cy)
  );

  always_comb begin
    acc_nx = acc_r;
    flg_nx = flg_r;
    if (en) begin
      if (op_e == OP_DADJ) begin
        acc_nx      = da_res;
        flg_nx.cy   = da_cy;
        flg_nx.ac   = da_ac;
        flg_nx.zero = (da_res == '0);
        flg_nx.sign = da_res[ACC_W-1];
        flg_nx.par  = ~^da_res;
      end else begin
        acc_nx    = bo_res;
        flg_nx.cy = bo_cy;
        flg_nx.ac = ac_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
      flg_r <= '0;
    end else begin
      acc_r <= acc_nx;
      flg_r <= flg_nx;
    end
  end

  assign acc_q  = acc_r;
  assign cy_q   = flg_r.cy;
  assign ac_q   = flg_r.ac;
  assign zero_q = flg_r.zero;
  assign sign_q = flg_r.sign;
  assign par_q  = flg_r.par;

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_q) && $stable(cy_q) && $stable(ac_q)
             && $stable(zero_q) && $stable(sign_q) && $stable(par_q)));

  a_r7_rlc_carry_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd1) |=> (acc_q[0] == cy_q) && (cy_q == $past(acc_in[7])));

  a_r8_rlt_carry_in: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd3) |=> (acc_q[0] == $past(cy_in)) && (cy_q == $past(acc_in[7])));

  a_r9_rotate_keeps_zsp: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 3'd1 && op <= 3'd4) |=>
      ($stable(zero_q) && $stable(sign_q) && $stable(par_q)));

  a_r10_cpl_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd5) |=> (acc_q == ~$past(acc_in)) && (cy_q == $past(cy_in)));

  a_r11_setc_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd7) |=> cy_q && (acc_q == $past(acc_in)));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 3'd0) |=> (zero_q == (acc_q == 8'h00)) && (sign_q == acc_q[7]));
endmodule

// File: tb/sim_acc_adjust_unit.sv
module sim_acc_adjust_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] op;
  logic [7:0] acc_in;
  logic       cy_in;
  logic       ac_in;
  logic [7:0] acc_q;
  logic       cy_q, ac_q, zero_q, sign_q, par_q;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_acc;
  bit m_cy, m_ac, m_z, m_s, m_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_adjust_unit u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_in(acc_in),
    .cy_in(cy_in), .ac_in(ac_in), .acc_q(acc_q), .cy_q(cy_q),
    .ac_q(ac_q), .zero_q(zero_q), .sign_q(sign_q), .par_q(par_q)
  );

  function automatic string tag_of(input bit e, input int o);
    if (!e) return "R2";
    case (o)
      0: return "R4/R5/R6";
      1, 2: return "R7/R9";
      3, 4: return "R8/R9";
      5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step(input bit e, input int o, input int a, input bit c, input bit h);
    int r, ones;
    if (!e) return;
    case (o)
      0: begin
        r = a;
        m_cy = c;
        m_ac = 0;
        if ((a % 16) > 9 || h) begin
          m_ac = ((a % 16) + 6) >= 16;
          r = r + 6;
        end
        if (r >= 256) begin m_cy = 1; r = r - 256; end
        if ((r / 16) > 9 || m_cy) r = r + 96;
        if (r >= 256) begin m_cy = 1; r = r - 256; end
        m_acc = r;
        m_z = (r == 0);
        m_s = (r >= 128);
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        m_p = (ones % 2 == 0);
      end
      1: begin m_acc = ((a * 2) % 256) + (a / 128); m_cy = (a >= 128); m_ac = h; end
      2: begin m_acc = (a / 2) + 128 * (a % 2); m_cy = a % 2; m_ac = h; end
      3: begin m_acc = ((a * 2) % 256) + c; m_cy = (a >= 128); m_ac = h; end
      4: begin m_acc = (a / 2) + 128 * c; m_cy = a % 2; m_ac = h; end
      5: begin m_acc = 255 - a; m_cy = c; m_ac = h; end
      6: begin m_acc = a; m_cy = !c; m_ac = h; end
      default: begin m_acc = a; m_cy = 1; m_ac = h; end
    endcase
  endtask

  task automatic compare(input string tag);
    n_run++;
    if (acc_q !== 8'(m_acc) || cy_q !== m_cy || ac_q !== m_ac ||
        zero_q !== m_z || sign_q !== m_s || par_q !== m_p) begin
      n_fail++;
      $display("FAIL %s: got acc=%02h cy=%0b ac=%0b z=%0b s=%0b p=%0b, expected acc=%02h cy=%0b ac=%0b z=%0b s=%0b p=%0b",
               tag, acc_q, cy_q, ac_q, zero_q, sign_q, par_q,
               8'(m_acc), m_cy, m_ac, m_z, m_s, m_p);
    end
  endtask

  // one enabled or idle step; inputs set at the falling edge, result checked one falling edge later (R3)
  task automatic step(input bit e, input int o, input int a, input bit c, input bit h);
    en = e; op = 3'(o); acc_in = 8'(a); cy_in = c; ac_in = h;
    @(posedge clk);
    model_step(e, o, a, c, h);
    @(negedge clk);
    compare({tag_of(e, o), " R3"});
  endtask

  // binary add computed in the bench, followed by a decimal adjust
  task automatic add_then_adjust(input int x, input int y);
    int s;
    bit h;
    s = x + y;
    h = ((x % 16) + (y % 16)) >= 16;
    step(1, 0, s % 256, s >= 256, h);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; op = 0; acc_in = 0; cy_in = 0; ac_in = 0;
    m_acc = 0; m_cy = 0; m_ac = 0; m_z = 0; m_s = 0; m_p = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    // R4/R5: decimal additions
    add_then_adjust(8'h38, 8'h45);  // 7D -> 83
    add_then_adjust(8'h29, 8'h19);  // 42 with half carry -> 48
    add_then_adjust(8'h99, 8'h01);  // 9A -> 00 carry, zero
    add_then_adjust(8'h99, 8'h99);  // 132 -> 98 carry
    add_then_adjust(8'h50, 8'h50);  // A0 -> 00 carry
    add_then_adjust(8'h12, 8'h34);  // no correction
    step(1, 0, 8'h9A, 0, 0);        // R5: low fix pushes high digit to A
    step(1, 0, 8'hFF, 0, 0);        // R5: low fix overflows bit 7
    step(1, 0, 8'h00, 1, 1);        // R4/R5 flags alone force both fixes

    // R9/R10/R11: zsp held after a decimal result
    step(1, 0, 8'h00, 0, 0);        // zero result, sets z and p
    step(1, 1, 8'h81, 0, 1);
    step(1, 2, 8'h01, 0, 0);
    step(1, 3, 8'h80, 1, 0);
    step(1, 4, 8'h01, 1, 1);
    step(1, 4, 8'h00, 0, 0);
    step(1, 5, 8'h5A, 1, 0);
    step(1, 6, 8'h33, 1, 1);
    step(1, 6, 8'h33, 0, 0);
    step(1, 7, 8'hC3, 0, 1);

    // R2: enable low leaves everything alone
    step(0, 5, 8'hFF, 1, 1);
    step(0, 0, 8'h9F, 1, 1);

    // mixed sequences
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 5) != 0, $urandom % 8, $urandom % 256,
           $urandom % 2, $urandom % 2);
    end

    // R1: reset in mid-run returns to the reset state
    step(1, 5, 8'h00, 1, 1);
    rst_n = 0;
    #1;
    m_acc = 0; m_cy = 0; m_ac = 0; m_z = 0; m_s = 0; m_p = 0;
    compare("R1 async reset");
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule